// File: doc/BRIEF.md
# Overtemperature Alarm Output Stage

This block turns a stream of temperature samples into a single alarm pin. Every valid sample is compared, as a signed value, against two programmable limits: a trip limit and a lower re-arm limit. The result drives one pin whose active level is programmable. The temperature source, the converter and the serial register bus sit outside the block. Register writes arrive as simple write strobes with data. A read of the temperature register elsewhere in the chip reaches this block as a one-cycle clear pulse.

There are two alarm modes. In follow mode the alarm tracks temperature with hysteresis. In event mode it latches an event until the clear pulse arrives, and the events alternate between "went above trip" and "went below re-arm". A shutdown bit stops sample evaluation. What happens to the pin when shutdown is entered depends on the mode. After reset the block runs in follow mode with an active-low pin, a trip limit of 80 °C and a re-arm limit of 75 °C.

Top module: `thermwd_top`

## Requirements
- R1: After reset the trip limit is 160 (80 °C), the re-arm limit is 150 (75 °C) and the configuration is 3'b000 (running, follow mode, active-low), so alarm_pin is high.
- R2: Samples and limits are 9-bit two's-complement values at 0.5 °C per LSB, and all comparisons are signed (for example, sample -1 is above a trip limit of -2).
- R3: In follow mode (cfg bit1 = 0), a valid sample strictly greater than the trip limit makes the alarm active from the clock edge that takes the sample.
- R4: In follow mode an active alarm stays active until a valid sample is strictly below the re-arm limit. A sample equal to the trip limit does not activate an inactive alarm.
- R5: In event mode (cfg bit1 = 1), while armed for a high event, a valid sample strictly above the trip limit activates the alarm. Later samples leave it active until it is cleared.
- R6: In event mode rd_clr deactivates the alarm. The next event is then a valid sample strictly below the re-arm limit, and events keep alternating between high and low.
- R7: In follow mode rd_clr has no effect on the alarm.
- R8: cfg bit2 = 1 makes the pin active-high and cfg bit2 = 0 makes it active-low. The new level appears right after the edge that writes the bit.
- R9: While cfg bit0 (shutdown) is 1, samples are ignored.
- R10: Entering shutdown in follow mode leaves the pin level unchanged.
- R11: Entering shutdown in event mode returns the alarm to inactive.
- R12: A configuration write that changes bit1 resets the alarm to inactive, and event mode starts armed for a high event.
- R13: trip_wr and rearm_wr load their 9-bit data. The new limit applies to samples from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | New temperature sample strobe |
| samp_temp | input | 9 | Signed sample, 0.5 °C per LSB |
| trip_wr | input | 1 | Write strobe for the trip limit |
| trip_wdata | input | 9 | New trip limit |
| rearm_wr | input | 1 | Write strobe for the re-arm limit |
| rearm_wdata | input | 9 | New re-arm limit |
| cfg_wr | input | 1 | Write strobe for configuration |
| cfg_wdata | input | 3 | bit2 polarity (1 = active-high), bit1 mode (1 = event), bit0 shutdown |
| rd_clr | input | 1 | Clear pulse from a temperature register read |
| alarm_pin | output | 1 | Alarm output level |

## Verification
Any internal state error reaches the pin in the same cycle it occurs, because the pin is a pure function of the alarm state and the polarity bit. A stuck or wrongly toggled event direction stays hidden until the next clear. The following ramp then shows it, either as a missing event or as an event fired at the wrong limit. Full ramps of all 512 codes, up and down, under several limit pairs, both polarities and both modes, expose off-by-one or unsigned comparisons exactly at the limit codes. A wrong reset default shows on the first sample at 80.5 °C.

// File: rtl/thermwd_pkg.sv
package thermwd_pkg;

    parameter int TEMP_W = 9;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic {
        MODE_FOLLOW = 1'b0,
        MODE_EVENT  = 1'b1
    } amode_e;

    // bit2 polarity, bit1 mode, bit0 shutdown
    typedef struct packed {
        logic   pol_hi;
        amode_e mode;
        logic   shdn;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_DFLT = '{pol_hi: 1'b0, mode: MODE_FOLLOW, shdn: 1'b0};

    // A qualified sample: valid only when conversion is running
    typedef struct packed {
        logic valid;
        logic above;
        logic below;
    } samp_ev_t;

    function automatic logic is_above(temp_t s, temp_t lim);
        return s > lim;
    endfunction

    function automatic logic is_below(temp_t s, temp_t lim);
        return s < lim;
    endfunction

    function automatic logic pin_level(logic act, logic pol_hi);
        return pol_hi ? act : ~act;
    endfunction

endpackage

// File: rtl/thermwd_regs.sv
module thermwd_regs
    import thermwd_pkg::*;
#(
    parameter temp_t TRIP_RST  = temp_t'(160),
    parameter temp_t REARM_RST = temp_t'(150)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  trip_wr,
    input  temp_t trip_wdata,
    input  logic  rearm_wr,
    input  temp_t rearm_wdata,
    input  logic  cfg_wr,
    input  cfg_t  cfg_wdata,
    output temp_t trip_q,
    output temp_t rearm_q,
    output cfg_t  cfg_q,
    output logic  shdn_enter,
    output logic  mode_flip
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q  <= TRIP_RST;
            rearm_q <= REARM_RST;
            cfg_q   <= CFG_DFLT;
        end else begin
            if (trip_wr)  trip_q  <= trip_wdata;
            if (rearm_wr) rearm_q <= rearm_wdata;
            if (cfg_wr)   cfg_q   <= cfg_wdata;
        end
    end

    // Pulses seen in the cycle of the write, applied at the same edge
    assign shdn_enter = cfg_wr && cfg_wdata.shdn && !cfg_q.shdn;
    assign mode_flip  = cfg_wr && (cfg_wdata.mode != cfg_q.mode);

    assert_rst_dflt_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (trip_q == TRIP_RST && rearm_q == REARM_RST && cfg_q == CFG_DFLT));

endmodule

// File: rtl/thermwd_eval.sv
module thermwd_eval
    import thermwd_pkg::*;
(
    input  logic     samp_valid,
    input  temp_t    samp_temp,
    input  temp_t    trip_q,
    input  temp_t    rearm_q,
    input  logic     shdn,
    output samp_ev_t ev
);

    // Conversion halted in shutdown: no sample is qualified
    always_comb begin
        ev.valid = samp_valid && !shdn;
        ev.above = is_above(samp_temp, trip_q);
        ev.below = is_below(samp_temp, rearm_q);
    end

endmodule

// File: rtl/thermwd_alarm.sv
module thermwd_alarm
    import thermwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_t     cfg_q,
    input  logic     shdn_enter,
    input  logic     mode_flip,
    input  logic     rd_clr,
    input  samp_ev_t ev,
    output logic     active
);

    logic follow_act;   // follow-mode alarm state
    logic ev_pend;      // event-mode latched event
    logic ev_arm_lo;    // event mode: next event is a low crossing

    logic ev_hit;
    assign ev_hit = ev.valid && !ev_pend && (ev_arm_lo ? ev.below : ev.above);

    always_ff @(posedge clk) begin
        if (rst) begin
            follow_act <= 1'b0;
            ev_pend    <= 1'b0;
            ev_arm_lo  <= 1'b0;
        end else if (mode_flip) begin
            follow_act <= 1'b0;
            ev_pend    <= 1'b0;
            ev_arm_lo  <= 1'b0;
        end else if (cfg_q.mode == MODE_FOLLOW) begin
            if (ev.valid) begin
                if (ev.above)      follow_act <= 1'b1;
                else if (ev.below) follow_act <= 1'b0;
            end
        end else begin
            if (shdn_enter) begin
                ev_pend <= 1'b0;
            end else if (ev_hit) begin
                ev_pend   <= 1'b1;
                ev_arm_lo <= ~ev_arm_lo;
            end else if (rd_clr) begin
                ev_pend <= 1'b0;
            end
        end
    end

    assign active = (cfg_q.mode == MODE_EVENT) ? ev_pend : follow_act;

    assert_follow_set_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_FOLLOW && !mode_flip && ev.valid && ev.above) |=> follow_act);

    assert_follow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_FOLLOW && !mode_flip && !(ev.valid && (ev.above || ev.below)))
        |=> $stable(follow_act));

    assert_event_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_EVENT && !mode_flip && rd_clr && !ev.valid) |=> !ev_pend);

    assert_shdn_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.shdn && !mode_flip) |=> $stable(ev_arm_lo));

    assert_shdn_event_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_EVENT && shdn_enter) |=> !ev_pend);

    assert_mode_reset_R12: assert property (@(posedge clk) disable iff (rst)
        mode_flip |=> (!follow_act && !ev_pend && !ev_arm_lo));

endmodule

// File: rtl/thermwd_top.sv
module thermwd_top
    import thermwd_pkg::*;
#(
    parameter int TRIP_RST_CODE  = 160,
    parameter int REARM_RST_CODE = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  logic [TEMP_W-1:0] samp_temp,
    input  logic              trip_wr,
    input  logic [TEMP_W-1:0] trip_wdata,
    input  logic              rearm_wr,
    input  logic [TEMP_W-1:0] rearm_wdata,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              rd_clr,
    output logic              alarm_pin
);

    temp_t    trip_q, rearm_q;
    cfg_t     cfg_q;
    logic     shdn_enter, mode_flip;
    samp_ev_t ev;
    logic     active;

    thermwd_regs #(
        .TRIP_RST  (temp_t'(TRIP_RST_CODE)),
        .REARM_RST (temp_t'(REARM_RST_CODE))
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .trip_wr     (trip_wr),
        .trip_wdata  (temp_t'(trip_wdata)),
        .rearm_wr    (rearm_wr),
        .rearm_wdata (temp_t'(rearm_wdata)),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_t'(cfg_wdata)),
        .trip_q      (trip_q),
        .rearm_q     (rearm_q),
        .cfg_q       (cfg_q),
        .shdn_enter  (shdn_enter),
        .mode_flip   (mode_flip)
    );

    thermwd_eval u_eval (
        .samp_valid (samp_valid),
        .samp_temp  (temp_t'(samp_temp)),
        .trip_q     (trip_q),
        .rearm_q    (rearm_q),
        .shdn       (cfg_q.shdn),
        .ev         (ev)
    );

    thermwd_alarm u_alarm (
        .clk        (clk),
        .rst        (rst),
        .cfg_q      (cfg_q),
        .shdn_enter (shdn_enter),
        .mode_flip  (mode_flip),
        .rd_clr     (rd_clr),
        .ev         (ev),
        .active     (active)
    );

    assign alarm_pin = pin_level(active, cfg_q.pol_hi);

endmodule

// File: tb/tb_thermwd_top.sv
module tb_thermwd_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_valid = 1'b0;
    logic [8:0] samp_temp = '0;
    logic       trip_wr = 1'b0;
    logic [8:0] trip_wdata = '0;
    logic       rearm_wr = 1'b0;
    logic [8:0] rearm_wdata = '0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       rd_clr = 1'b0;
    logic       alarm_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    int m_trip = 160, m_rearm = 150;
    bit m_pol = 0, m_mode = 0, m_shdn = 0;
    bit m_fact = 0, m_pend = 0, m_lo = 0;

    always #10 clk = ~clk;   // 50 MHz

    thermwd_top dut (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_temp(samp_temp),
        .trip_wr(trip_wr), .trip_wdata(trip_wdata), .rearm_wr(rearm_wr),
        .rearm_wdata(rearm_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .rd_clr(rd_clr), .alarm_pin(alarm_pin)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req);
        bit act;
        bit exp;
        act = m_mode ? m_pend : m_fact;
        exp = m_pol ? act : !act;
        n_run++;
        if (alarm_pin !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm_pin=%b expected %b", req, alarm_pin, exp);
        end
    endtask

    task automatic samp(int t, string req);
        samp_valid = 1'b1;
        samp_temp  = 9'(t);
        if (!m_shdn) begin
            if (!m_mode) begin
                if (t > m_trip) m_fact = 1;
                else if (t < m_rearm) m_fact = 0;
            end else if (!m_pend) begin
                if (!m_lo && t > m_trip) begin m_pend = 1; m_lo = 1; end
                else if (m_lo && t < m_rearm) begin m_pend = 1; m_lo = 0; end
            end
        end
        cyc();
        samp_valid = 1'b0;
        check(req);
    endtask

    task automatic clr(string req);
        rd_clr = 1'b1;
        if (m_mode) m_pend = 0;
        cyc();
        rd_clr = 1'b0;
        check(req);
    endtask

    task automatic wcfg(bit pol, bit mode, bit shdn, string req);
        cfg_wr = 1'b1;
        cfg_wdata = {pol, mode, shdn};
        if (mode != m_mode) begin m_fact = 0; m_pend = 0; m_lo = 0; end
        if (mode && shdn && !m_shdn) m_pend = 0;
        m_pol = pol; m_mode = mode; m_shdn = shdn;
        cyc();
        cfg_wr = 1'b0;
        check(req);
    endtask

    task automatic wlim(int trip, int rearm);
        trip_wr = 1'b1;  trip_wdata = 9'(trip);
        rearm_wr = 1'b1; rearm_wdata = 9'(rearm);
        m_trip = trip; m_rearm = rearm;
        cyc();
        trip_wr = 1'b0; rearm_wr = 1'b0;
    endtask

    task automatic ramp(bit ev_mode, string req);
        for (int t = -256; t <= 255; t++) begin
            samp(t, req);
            if (ev_mode && (t % 37 == 0)) clr(req);
        end
        for (int t = 255; t >= -256; t--) begin
            samp(t, req);
            if (ev_mode && (t % 41 == 0)) clr(req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pin");
        // defaults and strict compare
        samp(160, "R4 equal to trip");
        samp(161, "R1 default trip R3");
        samp(150, "R4 hold at re-arm");
        samp(149, "R4 below re-arm");
        samp(161, "R3 set again");
        clr("R7 clear ignored");
        // shutdown in follow mode
        wcfg(0, 0, 1, "R10 enter shutdown follow");
        samp(-50, "R9 sample ignored");
        wcfg(0, 0, 0, "R9 leave shutdown");
        samp(149, "R4 drop");
        // event mode
        wcfg(0, 1, 0, "R12 to event");
        samp(161, "R5 high event");
        samp(100, "R5 latched");
        clr("R6 clear");
        samp(200, "R6 armed low");
        samp(149, "R6 low event");
        clr("R6 clear low");
        samp(161, "R6 alternate high");
        wcfg(0, 1, 1, "R11 shutdown event");
        samp(-100, "R9 ignored event");
        wcfg(0, 1, 0, "R9 resume");
        wcfg(1, 1, 0, "R8 active-high");
        // signed limits
        wlim(-2, -4);
        wcfg(1, 0, 0, "R12 to follow");
        samp(-1, "R2 signed above R13");
        samp(-4, "R2 hold");
        samp(-5, "R2 signed below");
        samp(0, "R12 prep");
        wcfg(1, 1, 0, "R12 flip clears");
        // sweeps
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: wlim(160, 150);
                1: wlim(10, -10);
                2: wlim(-20, -30);
                default: wlim(255, -256);
            endcase
            for (int pol = 0; pol < 2; pol++) begin
                wcfg(bit'(pol), 0, 0, "R8 sweep cfg");
                ramp(0, "R3 R4 follow sweep");
                wcfg(bit'(pol), 1, 0, "R12 sweep cfg");
                ramp(1, "R5 R6 event sweep");
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule